// File: doc/BRIEF.md
# Channel-Partitioned Audio Sample FIFO

This block is the sample store that sits between a bus-side write port and an audio serializer. It keeps up to 256 words of 24-bit sample data. The slice of that storage a stream may use depends on how many interleaved channels the stream carries. Occupancy is reported in whole channel-frames rather than words, so software multiplies the reported value by the channel count to get words.

Each instance serves one port (A or B) in one direction (output or input), chosen by parameters. Its control and status words sit in a small window that moves up by 0x40 for port B. Interrupt status, interrupt mask and error mask are shared words, each with four source positions. The instance raises its own source bit when the fill level crosses the half-way mark. A software clear empties the store. Overrun and underrun are latched until cleared. A single interrupt line combines enabled sources and enabled errors.

Writes arrive as a plain valid/data pair. The serializer pops words with a read request and always sees the oldest stored word on the read data output.

Top module: `audio_frame_fifo`

## Requirements
- R1: After reset the store is empty (`rd_avail` low), the status word, control word, interrupt status, mask and error mask all read 0, and `irq` is low.
- R2: Words leave in the order they were accepted. Whenever `rd_avail` is high, `rd_data` shows the oldest stored word. A push and a pop in the same cycle are both taken when the store is neither full nor empty.
- R3: Capacity in words is the per-channel depth times the channel count. The per-channel depth is 256 for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8. A `chan_cnt` of 0 acts as 1, and values above 8 act as 8.
- R4: Status bits [16:8] hold the number of complete channel-frames stored, which is the word count divided by the channel count, rounded down.
- R5: A write while the store is full is dropped and sets the overrun flag at status bit 4. The flag stays set until a clear.
- R6: A read request while the store is empty changes nothing in the store and sets the underrun flag at status bit 0. The flag stays set until a clear.
- R7: Writing control bit 0 as 1 requests a clear. The bit reads 1 until the next clock edge. At that edge the store empties, both error flags reset and the bit returns to 0.
- R8: With control bit 20 set, the instance's source bit in interrupt status sets on each cycle where the half-way condition becomes true. The condition is fill ≤ capacity/2 for output and fill ≥ capacity/2 for input. The source bit positions are 0 for port A output, 4 for port A input, 8 for port B output and 12 for port B input.
- R9: A write to interrupt status keeps each source bit written as 1 and clears each written as 0. Only bits 0, 4, 8 and 12 exist. A set from R8 in the same cycle wins.
- R10: `irq` is high when any interrupt status bit is set with the same mask bit set, or when either error flag is set and the error mask holds a 1 at the instance's source position.
- R11: Control is at window+0x00 and status at window+0x04, where the window is 0x00 for port A and 0x40 for port B. Interrupt status is at 0x200, mask at 0x204 and error mask at 0x208. Mask and error mask keep only bits 0, 4, 8 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Sample write strobe |
| wr_data | input | DW | Sample word to store |
| rd_req | input | 1 | Pop request from the serializer |
| rd_data | output | DW | Oldest stored word |
| rd_avail | output | 1 | Store is not empty |
| chan_cnt | input | 4 | Interleaved channel count (1..8) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is the half-way interrupt firing again after software has cleared it. The fill level has to leave the half-way region and then come back, so the bench fills a two-channel stream one word past half and pops a single word to re-enter the region. Capacity limits for odd channel counts are reached by driving writes well past 192 and 160 words and then draining every word to confirm that the surplus was dropped. A seeded random mix of pushes and pops, over several channel counts, keeps the store near full and near empty so that overrun and underrun arise alongside ordinary traffic.

// File: rtl/audio_frame_fifo.sv
module audio_frame_fifo #(
  parameter int DW       = 24,
  parameter int DEPTH    = 256,
  parameter int AW       = 10,
  parameter bit PORT_B   = 1'b0,
  parameter bit IS_INPUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_avail,
  input  logic [3:0]    chan_cnt,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;
  localparam int WIN = PORT_B ? 'h40 : 0;
  localparam int SRC = (PORT_B ? 8 : 0) + (IS_INPUT ? 4 : 0);
  localparam logic [AW-1:0] A_CTL  = AW'(WIN);
  localparam logic [AW-1:0] A_STAT = AW'(WIN + 4);
  localparam logic [AW-1:0] A_IST  = AW'('h200);
  localparam logic [AW-1:0] A_IMSK = AW'('h204);
  localparam logic [AW-1:0] A_EMSK = AW'('h208);
  localparam logic [DW-1:0] SRC_MASK = DW'(32'h1111);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count, cap, perch, frames;
  logic [3:0]    ch_eff;
  logic          ovr, und, clr_pend, ctl_half, hc, hc_q;
  logic [DW-1:0] ist, ist_nx, imsk, emsk, stat_w;

  assign ch_eff = (chan_cnt == 4'd0) ? 4'd1 : (chan_cnt > 4'd8) ? 4'd8 : chan_cnt;
  assign perch  = (ch_eff == 4'd1) ? CW'(DEPTH)   :
                  (ch_eff == 4'd2) ? CW'(DEPTH/2) :
                  (ch_eff <= 4'd4) ? CW'(DEPTH/4) : CW'(DEPTH/8);
  assign cap    = CW'(32'(perch) * 32'(ch_eff));
  assign frames = CW'(32'(count) / 32'(ch_eff));

  wire full  = count >= cap;
  wire empty = count == '0;
  wire push  = wr_valid && !full  && !clr_pend;
  wire pop   = rd_req   && !empty && !clr_pend;

  assign rd_data  = mem[rp];
  assign rd_avail = !empty;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ovr <= 1'b0; und <= 1'b0;
    end else if (clr_pend) begin
      wp <= '0; rp <= '0; count <= '0; ovr <= 1'b0; und <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (wr_valid && full) ovr <= 1'b1;
      if (rd_req && empty)  und <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clr_pend <= 1'b0; ctl_half <= 1'b0;
    end else if (reg_we && reg_addr == A_CTL) begin
      clr_pend <= reg_wdata[0]; ctl_half <= reg_wdata[20];
    end else begin
      clr_pend <= 1'b0;
    end

  assign hc = ctl_half && (IS_INPUT ? ({count, 1'b0} >= {1'b0, cap})
                                    : ({count, 1'b0} <= {1'b0, cap}));

  always_comb begin
    ist_nx = ist;
    if (reg_we && reg_addr == A_IST) ist_nx = ist & reg_wdata & SRC_MASK;
    if (hc && !hc_q) ist_nx[SRC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ist <= '0; imsk <= '0; emsk <= '0; hc_q <= 1'b0;
    end else begin
      ist  <= ist_nx;
      hc_q <= hc;
      if (reg_we && reg_addr == A_IMSK) imsk <= reg_wdata & SRC_MASK;
      if (reg_we && reg_addr == A_EMSK) emsk <= reg_wdata & SRC_MASK;
    end

  assign irq = (|(ist & imsk)) || ((ovr || und) && emsk[SRC]);

  always_comb begin
    stat_w = '0;
    stat_w[8 +: CW] = frames;
    stat_w[4] = ovr;
    stat_w[0] = und;
  end

  always_comb
    case (reg_addr)
      A_CTL:   begin reg_rdata = '0; reg_rdata[20] = ctl_half; reg_rdata[0] = clr_pend; end
      A_STAT:  reg_rdata = stat_w;
      A_IST:   reg_rdata = ist;
      A_IMSK:  reg_rdata = imsk;
      A_EMSK:  reg_rdata = emsk;
      default: reg_rdata = '0;
    endcase

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pend |=> (count == $past(count) || count == $past(count) + 1'b1 || count + 1'b1 == $past(count)));
  assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_avail && full && !clr_pend) |=> ovr);
  assert_underrun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_avail && !clr_pend && !wr_valid) |=> (und && !rd_avail));
  assert_clear_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> (!rd_avail && !ovr && !und));
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (imsk == '0 && emsk == '0) |-> !irq);
endmodule

// File: tb/audio_frame_fifo_test.sv
`timescale 1ns/1ps
module audio_frame_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_req = 1'b0, reg_we = 1'b0;
  logic [23:0] wr_data = '0, reg_wdata = '0, rd_data, reg_rdata;
  logic [3:0]  chan_cnt = 4'd1;
  logic [9:0]  reg_addr = 10'h004;
  logic rd_avail, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [23:0] q[$];
  bit e_ovr = 1'b0, e_und = 1'b0;

  localparam logic [9:0] CTL = 10'h000, ST = 10'h004, IST = 10'h200, IMSK = 10'h204, EMSK = 10'h208;

  audio_frame_fifo uut (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .rd_avail(rd_avail), .chan_cnt(chan_cnt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #4 clk = ~clk;

  function automatic int eff(input int c);
    return (c == 0) ? 1 : (c > 8) ? 8 : c;
  endfunction
  function automatic int cap_of(input int c);
    int e = eff(c);
    int p = (e == 1) ? 256 : (e == 2) ? 128 : (e <= 4) ? 64 : 32;
    return p * e;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rreg(input logic [9:0] a, output logic [23:0] v);
    reg_addr = a; #1; v = reg_rdata; reg_addr = ST;
  endtask

  task automatic wreg(input logic [9:0] a, input logic [23:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = ST;
  endtask

  task automatic cyc(input bit w, input bit r);
    logic [23:0] d = 24'($urandom);
    logic [23:0] s;
    bit full = (q.size() >= cap_of(int'(chan_cnt)));
    bit empt = (q.size() == 0);
    wr_valid = w; wr_data = d; rd_req = r;
    step();
    wr_valid = 1'b0; rd_req = 1'b0;
    if (r && !empt) void'(q.pop_front());
    if (r && empt) e_und = 1'b1;
    if (w && !full) q.push_back(d);
    if (w && full) e_ovr = 1'b1;
    check("R2 avail", int'(rd_avail), int'(q.size() != 0));
    if (q.size() != 0) check("R2 head", int'(rd_data), int'(q[0]));
    rreg(ST, s);
    check("R4 frames", int'(s[16:8]), q.size() / eff(int'(chan_cnt)));
    check("R5 ovr", int'(s[4]), int'(e_ovr));
    check("R6 und", int'(s[0]), int'(e_und));
  endtask

  task automatic do_clear(input logic [23:0] keep);
    logic [23:0] v;
    wreg(CTL, keep | 24'h1);
    rreg(CTL, v);
    check("R7 clr bit pending", int'(v[0]), 1);
    step();
    q.delete(); e_ovr = 1'b0; e_und = 1'b0;
    rreg(CTL, v);
    check("R7 clr bit self-clears", int'(v[0]), 0);
    rreg(ST, v);
    check("R7 status after clear", int'(v), 0);
    check("R7 empty after clear", int'(rd_avail), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    void'($urandom(32'd4242));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 avail", int'(rd_avail), 0);
    check("R1 irq", int'(irq), 0);
    rreg(ST, v);   check("R1 status", int'(v), 0);
    rreg(CTL, v);  check("R1 ctl", int'(v), 0);
    rreg(IST, v);  check("R1 ist", int'(v), 0);
    rreg(IMSK, v); check("R1 imsk", int'(v), 0);
    rreg(EMSK, v); check("R1 emsk", int'(v), 0);

    // R2 / R4 one channel
    chan_cnt = 4'd1;
    repeat (5) cyc(1'b1, 1'b0);
    repeat (5) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    repeat (2) cyc(1'b0, 1'b1);

    // R3 / R5 / R6 three channels: capacity 192
    do_clear(24'h0);
    chan_cnt = 4'd3;
    repeat (200) cyc(1'b1, 1'b0);
    check("R3 cap 3ch", q.size(), 192);
    repeat (192) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    check("R6 underrun set", int'(e_und), 1);

    // R3 five channels: capacity 160; channel count 0 acts as 1
    do_clear(24'h0);
    chan_cnt = 4'd5;
    repeat (170) cyc(1'b1, 1'b0);
    check("R3 cap 5ch", q.size(), 160);
    do_clear(24'h0);
    chan_cnt = 4'd0;
    repeat (7) cyc(1'b1, 1'b0);
    chan_cnt = 4'd12;
    do_clear(24'h0);
    repeat (9) cyc(1'b1, 1'b0);

    // R8 / R9 half-way request, two channels (cap 256)
    chan_cnt = 4'd2;
    do_clear(24'h0);
    wreg(CTL, 24'h100000);
    step();
    rreg(IST, v); check("R8 half on enable", int'(v), 24'h000001);
    wreg(IST, 24'h001111);
    rreg(IST, v); check("R9 write one keeps", int'(v), 24'h000001);
    wreg(IMSK, 24'hFFFFFF);
    rreg(IMSK, v); check("R11 mask bits only", int'(v), 24'h001111);
    check("R10 irq masked source", int'(irq), 1);
    wreg(IMSK, 24'h0);
    check("R10 irq unmasked", int'(irq), 0);
    wreg(IST, 24'h000000);
    rreg(IST, v); check("R9 write zero clears", int'(v), 0);
    repeat (129) cyc(1'b1, 1'b0);
    rreg(IST, v); check("R8 no request above half", int'(v), 0);
    cyc(1'b0, 1'b1);
    step();
    rreg(IST, v); check("R8 re-entry sets bit0", int'(v), 24'h000001);
    wreg(IST, 24'h000010);
    rreg(IST, v); check("R9 cannot set absent source", int'(v), 0);
    rreg(10'h040, v); check("R11 port B window unused", int'(v), 0);
    rreg(CTL, v); check("R11 ctl half bit", int'(v), 24'h100000);

    // R10 error mask path
    repeat (130) cyc(1'b1, 1'b0);
    check("R5 full overrun", int'(e_ovr), 1);
    wreg(EMSK, 24'h000001);
    check("R10 irq from error", int'(irq), 1);
    wreg(EMSK, 24'h000010);
    check("R10 other error bit ignored", int'(irq), 0);
    wreg(EMSK, 24'h0);

    // random phase over several channel counts
    for (int ph = 0; ph < 6; ph++) begin
      chan_cnt = 4'($urandom_range(1, 8));
      do_clear(24'h0);
      for (int i = 0; i < 1500; i++) begin
        bit w = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 70 : 35));
        bit r = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 35 : 70));
        cyc(w, r);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule